// File: doc/BRIEF.md
# Shadow RAM segment controller

This block steers CPU accesses to the upper memory area, the 256 KB window from 0xC0000 to 0xFFFFF, between a boot ROM and system RAM. Below 0xE0000 the window is cut into eight 16 KB segments. Above it there are two 64 KB segments. Each segment has two control bits. One picks the source of reads: ROM or RAM. The other decides whether writes reach RAM or are thrown away. Boot firmware uses this to copy ROM contents into RAM and then run from the faster copy.

Software reaches the control bits through a byte-wide index/data port pair. A write to offset 0 loads an index. Offset 1 then reads or writes the 256-entry register file at that index. Three of the entries hold the segment control bits. All other entries are plain storage.

On the memory side the block looks at the physical address and the read and write strobes of each access. It raises exactly one of three outputs: a ROM select, a RAM select or a write-discard flag. With a ROM read it also gives the byte offset into a 256 KB ROM image. RAM accesses keep their physical address unchanged.

Top module: `shadow_seg_ctrl`

## Requirements
- R1: A write at port offset 0 loads the register index. A write at offset 1 stores the data byte into the entry chosen by that index. A read at offset 1 returns that entry.
- R2: A read at any port offset other than 1 returns 0x00. This includes offset 0.
- R3: Reset clears all 256 entries to zero. After reset every segment from 0xC0000 to 0xFFFFF reads from ROM and discards writes.
- R4: Register 0x30 controls the four 16 KB segments from 0xC0000 to 0xCFFFF. The segment at 0xC0000 uses bits 1:0, 0xC4000 uses bits 3:2, 0xC8000 uses bits 5:4 and 0xCC000 uses bits 7:6.
- R5: Register 0x31 controls 0xD0000 to 0xDFFFF with the same layout: 0xD0000 in bits 1:0 and up to 0xDC000 in bits 7:6.
- R6: In register 0x32, bits 7:6 control the 64 KB segment at 0xE0000 and bits 5:4 control the 64 KB segment at 0xF0000. Bits 3:0 of this register, and every entry other than 0x30 to 0x32, have no effect on decoding.
- R7: Within a bit pair, the upper bit set sends reads to RAM and clear sends them to ROM. The lower bit set sends writes to RAM and clear raises the write-discard flag.
- R8: During a ROM read the ROM offset equals the address minus 0xC0000, as an 18-bit value. At all other times it is zero.
- R9: Any access outside 0xC0000 to 0xFFFFF selects RAM, whatever the registers hold.
- R10: A new register value governs the first memory access after the clock edge that completes the data-port write.
- R11: A write never selects ROM. At most one of ROM select, RAM select and write-discard is high, and all three are low when no strobe is active. If both strobes are high, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Port write strobe |
| cfg_addr | input | OFF_W (3) | Port offset |
| cfg_wdata | input | 8 | Port write data |
| cfg_rdata | output | 8 | Port read data (combinational) |
| mem_addr | input | ADDR_W (24) | Physical address of the access |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| rom_sel | output | 1 | Access is served by ROM |
| ram_sel | output | 1 | Access is served by RAM |
| rom_offset | output | 18 | Byte offset into the ROM image |
| wr_discard | output | 1 | Write is dropped |

## Verification
The bench sweeps all 256 values of each of the three control registers. After every value it hits the first and last byte of all ten segments, once with a read and once with a write. This catches a design that swaps the pair order within a register and maps a segment to its neighbour. It also catches one that swaps the two bits of a pair and ties reads to the write-enable bit, and one that decodes bits 3:0 of register 0x32 or swaps the two 64 KB segments. Addresses just outside the window on both sides and well above it must select RAM even when every control bit is set. An off-by-one window compare would fail there. Reads at every offset other than 1 must return zero with a nonzero entry selected. This exposes a port that ignores the offset or echoes the index.

// File: rtl/shadow_seg_pkg.sv
// Shared constants and types for the shadow segment controller.
// Assumes an 8-bit configuration port and a 256 KB upper memory window.
package shadow_seg_pkg;
    localparam int unsigned CFG_DW    = 8;
    localparam int unsigned ROM_OFF_W = 18;
    localparam logic [7:0]  REG_SEG_C  = 8'h30;
    localparam logic [7:0]  REG_SEG_D  = 8'h31;
    localparam logic [7:0]  REG_SEG_EF = 8'h32;
    localparam logic [1:0]  PAIR_E = 2'd3;
    localparam logic [1:0]  PAIR_F = 2'd2;

    typedef struct packed {
        logic rd_ram;
        logic wr_ram;
    } seg_ctl_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
// Index/data configuration port with an NREG x 8 register file.
// Offset 0 write loads the index; offset 1 accesses the indexed entry.
// Assumes NREG is a power of two no larger than 256.
module shadow_cfg_regs #(
    parameter int unsigned OFF_W = 3,
    parameter int unsigned NREG  = 256
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_wr,
    input  logic [OFF_W-1:0]                      cfg_addr,
    input  logic [shadow_seg_pkg::CFG_DW-1:0]     cfg_wdata,
    output logic [shadow_seg_pkg::CFG_DW-1:0]     cfg_rdata,
    output logic [shadow_seg_pkg::CFG_DW-1:0]     ctl_c,
    output logic [shadow_seg_pkg::CFG_DW-1:0]     ctl_d,
    output logic [shadow_seg_pkg::CFG_DW-1:0]     ctl_ef
);
    import shadow_seg_pkg::*;

    localparam int unsigned IDX_W = $clog2(NREG);
    localparam logic [OFF_W-1:0] OFF_INDEX = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_DATA  = OFF_W'(1);

    logic [IDX_W-1:0]  index_q;
    logic [CFG_DW-1:0] regs_q [NREG];

    // Index register: loaded by writes at the index offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (cfg_wr && cfg_addr == OFF_INDEX)
            index_q <= cfg_wdata[IDX_W-1:0];
    end

    // Register file: one generated flop row per entry, cleared on reset.
    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (cfg_wr && cfg_addr == OFF_DATA && index_q == IDX_W'(g))
                regs_q[g] <= cfg_wdata;
        end
    end

    // Read mux: only the data offset returns content.
    always_comb begin
        cfg_rdata = (cfg_addr == OFF_DATA) ? regs_q[index_q] : '0;
    end

    assign ctl_c  = regs_q[REG_SEG_C[IDX_W-1:0]];
    assign ctl_d  = regs_q[REG_SEG_D[IDX_W-1:0]];
    assign ctl_ef = regs_q[REG_SEG_EF[IDX_W-1:0]];
endmodule

// File: rtl/shadow_seg_lookup.sv
// Maps a physical address to its segment and returns that segment's
// read-source and write-enable bits. Also flags window membership.
// Assumes ADDR_W >= 20 and the window at 0xC0000-0xFFFFF.
module shadow_seg_lookup #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]                  mem_addr,
    input  logic [shadow_seg_pkg::CFG_DW-1:0]  ctl_c,
    input  logic [shadow_seg_pkg::CFG_DW-1:0]  ctl_d,
    input  logic [shadow_seg_pkg::CFG_DW-1:0]  ctl_ef,
    output logic                               in_uma,
    output shadow_seg_pkg::seg_ctl_t           seg_ctl
);
    import shadow_seg_pkg::*;

    localparam int unsigned TAG_W = ADDR_W - ROM_OFF_W;
    localparam logic [TAG_W-1:0] UMA_TAG = TAG_W'(3);
    localparam int unsigned NPAIR = CFG_DW / 2;

    logic [CFG_DW-1:0] sel_reg;
    logic [1:0]        pair_idx;
    seg_ctl_t          pairs [NPAIR];

    // Window check: address bits above the 256 KB offset must equal 3.
    assign in_uma = (mem_addr[ADDR_W-1:ROM_OFF_W] == UMA_TAG);

    // Register and pair choice: 16 KB pairs below 0xE0000, fixed pairs above.
    always_comb begin
        if (mem_addr[17]) begin
            sel_reg  = ctl_ef;
            pair_idx = mem_addr[16] ? PAIR_F : PAIR_E;
        end else begin
            sel_reg  = mem_addr[16] ? ctl_d : ctl_c;
            pair_idx = mem_addr[15:14];
        end
    end

    // Split the chosen register into its bit pairs.
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pairs[g].rd_ram = sel_reg[2*g+1];
        assign pairs[g].wr_ram = sel_reg[2*g];
    end

    assign seg_ctl = pairs[pair_idx];
endmodule

// File: rtl/shadow_seg_ctrl.sv
// Top of the shadow segment controller: configuration port, segment
// lookup and the ROM/RAM/discard steering of each memory access.
// Assumes one access per cycle; a write strobe overrides a read strobe.
module shadow_seg_ctrl #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned NREG   = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [OFF_W-1:0]  cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic [17:0]       rom_offset,
    output logic              wr_discard
);
    import shadow_seg_pkg::*;

    logic [CFG_DW-1:0] ctl_c, ctl_d, ctl_ef;
    logic              in_uma;
    seg_ctl_t          seg_ctl;
    logic              is_wr, is_rd;

    shadow_cfg_regs #(.OFF_W(OFF_W), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_c     (ctl_c),
        .ctl_d     (ctl_d),
        .ctl_ef    (ctl_ef)
    );

    shadow_seg_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .mem_addr (mem_addr),
        .ctl_c    (ctl_c),
        .ctl_d    (ctl_d),
        .ctl_ef   (ctl_ef),
        .in_uma   (in_uma),
        .seg_ctl  (seg_ctl)
    );

    assign is_wr = mem_wr;
    assign is_rd = mem_rd & ~mem_wr;

    // Steering: choose ROM, RAM or discard for the current access.
    always_comb begin
        rom_sel    = is_rd & in_uma & ~seg_ctl.rd_ram;
        ram_sel    = (is_rd & (~in_uma | seg_ctl.rd_ram))
                   | (is_wr & (~in_uma | seg_ctl.wr_ram));
        wr_discard = is_wr & in_uma & ~seg_ctl.wr_ram;
        rom_offset = rom_sel ? mem_addr[ROM_OFF_W-1:0] : '0;
    end
endmodule

// File: rtl/shadow_seg_ctrl_chk.sv
// Property checker for shadow_seg_ctrl, attached by bind below.
module shadow_seg_ctrl_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [OFF_W-1:0]  cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              rom_sel,
    input logic              ram_sel,
    input logic [17:0]       rom_offset,
    input logic              wr_discard
);
    localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(1);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(20'hC0000);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(20'hFFFFF);

    logic outside;
    assign outside = (mem_addr < WIN_LO) || (mem_addr > WIN_HI);

    // R1: data written at the data offset is read back on the next cycle
    a_r1_data_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == OFF_DATA) |=>
        (cfg_addr != OFF_DATA || cfg_rdata == $past(cfg_wdata)));

    // R2: other offsets read as zero
    a_r2_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != OFF_DATA) |-> (cfg_rdata == 8'h00));

    // R8: ROM offset tracks the address relative to the window base
    a_r8_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (ADDR_W'(rom_offset) == mem_addr - WIN_LO));

    // R9: outside the window every access goes to RAM
    a_r9_outside_ram: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && outside) |-> (ram_sel && !rom_sel && !wr_discard));

    // R11: a write never selects ROM
    a_r11_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !rom_sel);

    // R11: at most one outcome, none without a strobe
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, wr_discard}) &&
        ((mem_rd || mem_wr) || !(rom_sel || ram_sel || wr_discard)));
endmodule

bind shadow_seg_ctrl shadow_seg_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .rom_sel    (rom_sel),
    .ram_sel    (ram_sel),
    .rom_offset (rom_offset),
    .wr_discard (wr_discard)
);

// File: tb/shadow_seg_ctrl_bench.sv
// Self-checking sweep bench for shadow_seg_ctrl.
module shadow_seg_ctrl_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned OFF_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [OFF_W-1:0]  cfg_addr = '0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              mem_rd = 1'b0;
    logic              mem_wr = 1'b0;
    logic              rom_sel, ram_sel, wr_discard;
    logic [17:0]       rom_offset;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;
    logic [7:0]  model [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_seg_ctrl u_shadow_seg_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .rom_offset(rom_offset), .wr_discard(wr_discard)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic port_write(input logic [OFF_W-1:0] off, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        port_write(0, idx);
        port_write(1, d);
        if (idx >= 8'h30 && idx <= 8'h32) model[idx - 8'h30] = d;
    endtask

    task automatic port_read(input string tag, input logic [OFF_W-1:0] off, input logic [7:0] exp);
        cfg_addr = off;
        #1;
        check(tag, {24'd0, cfg_rdata}, {24'd0, exp});
    endtask

    // Expected {rom_sel, ram_sel, wr_discard, rom_offset}, worked out from the requirements.
    function automatic logic [20:0] expect_out(input int unsigned a, input bit wr);
        logic [7:0] r;
        int unsigned p;
        bit rd_ram, wr_ram;
        if (a < 32'hC0000 || a > 32'hFFFFF) return {1'b0, 1'b1, 1'b0, 18'd0};
        if (a < 32'hE0000) begin
            r = (a < 32'hD0000) ? model[0] : model[1];
            p = ((a - 32'hC0000) >> 14) % 4;
        end else begin
            r = model[2];
            p = (a < 32'hF0000) ? 3 : 2;
        end
        rd_ram = r[2*p+1];
        wr_ram = r[2*p];
        if (wr) return {1'b0, wr_ram, !wr_ram, 18'd0};
        if (rd_ram) return {1'b0, 1'b1, 1'b0, 18'd0};
        return {1'b1, 1'b0, 1'b0, 18'(a - 32'hC0000)};
    endfunction

    task automatic access(input string tag, input int unsigned a, input bit wr);
        @(negedge clk);
        mem_addr = ADDR_W'(a); mem_wr = wr; mem_rd = !wr;
        #1;
        check(tag, {11'd0, rom_sel, ram_sel, wr_discard, rom_offset},
              {11'd0, expect_out(a, wr)});
    endtask

    task automatic sweep_window(input string tag);
        for (int s = 0; s < 10; s++) begin
            int unsigned base = (s < 8) ? 32'hC0000 + s * 32'h4000 : 32'hE0000 + (s - 8) * 32'h10000;
            int unsigned last = base + ((s < 8) ? 32'h3FFF : 32'hFFFF);
            access(tag, base, 1'b0);
            access(tag, last, 1'b0);
            access(tag, base, 1'b1);
            access(tag, last, 1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model[0] = '0; model[1] = '0; model[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: register file and segment state after reset
        port_read("R3 reset idx0", 1, 8'h00);
        port_write(0, 8'h30); port_read("R3 reset reg30", 1, 8'h00);
        port_write(0, 8'hFF); port_read("R3 reset regFF", 1, 8'h00);
        sweep_window("R3 reset window");

        // R1: index/data access to a plain entry; R2: other offsets read zero
        set_reg(8'h7F, 8'hA5);
        port_read("R1 readback", 1, 8'hA5);
        for (int o = 0; o < 8; o++) if (o != 1) port_read("R2 other offset", OFF_W'(o), 8'h00);
        set_reg(8'h00, 8'h3C);
        port_write(0, 8'h7F); port_read("R1 entry kept", 1, 8'hA5);
        port_write(0, 8'h00); port_read("R1 second entry", 1, 8'h3C);

        // R11: no strobe gives no outcome
        @(negedge clk); mem_rd = 0; mem_wr = 0; mem_addr = ADDR_W'(32'hC0000); #1;
        check("R11 idle", {29'd0, rom_sel, ram_sel, wr_discard}, 32'd0);

        // R4 R5 R6 R7 R8 R10: every value of each control register
        for (int rg = 0; rg < 3; rg++) begin
            for (int v = 0; v < 256; v++) begin
                set_reg(8'h30 + 8'(rg), 8'(v));
                // R10: first access right after the write edge sees the new value
                access(rg == 0 ? "R10 R4 first access" : (rg == 1 ? "R10 R5 first access" : "R10 R6 first access"),
                       (rg == 0) ? 32'hCC000 : ((rg == 1) ? 32'hD0000 : 32'hF0000), 1'b0);
                sweep_window(rg == 0 ? "R4 R7 R8" : (rg == 1 ? "R5 R7 R8" : "R6 R7 R8"));
            end
            port_write(0, 8'h30 + 8'(rg));
            port_read("R1 control readback", 1, 8'hFF);
        end

        // R9: outside the window, with every control bit set and then clear
        for (int k = 0; k < 2; k++) begin
            set_reg(8'h30, k ? 8'h00 : 8'hFF);
            set_reg(8'h31, k ? 8'h00 : 8'hFF);
            set_reg(8'h32, k ? 8'h00 : 8'hFF);
            access("R9 below", 32'h00000, 1'b0);
            access("R9 edge low", 32'hBFFFF, 1'b0);
            access("R9 edge low wr", 32'hBFFFF, 1'b1);
            access("R9 edge high", 32'h100000, 1'b0);
            access("R9 top wr", 32'hFFFFFF, 1'b1);
            access("R9 alias", 32'h1C0000, 1'b0);
        end

        // R6: low nibble of register 0x32 has no effect
        set_reg(8'h32, 8'h0F);
        access("R6 low nibble rd", 32'hE0000, 1'b0);
        access("R6 low nibble wr", 32'hFFFFF, 1'b1);

        // R11: both strobes treated as a write
        @(negedge clk); mem_addr = ADDR_W'(32'hE0000); mem_rd = 1; mem_wr = 1; #1;
        check("R11 both strobes", {29'd0, rom_sel, ram_sel, wr_discard}, 32'd1);
        @(negedge clk); mem_rd = 0; mem_wr = 0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule